// File: doc/BRIEF.md
# Eight-Lane Serial Requantizer

This unit sits behind a matrix engine that produces 64 signed 32-bit accumulator results in one word. It turns that word into 64 signed 8-bit values. It has eight arithmetic lanes instead of sixty-four, so one word takes eight output beats of eight bytes each. An internal beat counter selects which group of eight elements the lanes work on.

The producer hands over a word through a valid/ready handshake. The unit stores the whole word in a holding register on acceptance, together with the scale, shift and zero-point settings, so both the producer and the configuration source may change right away. Each lane multiplies its element by the signed scale, adds a rounding constant and shifts right arithmetically. It then adds the zero point and clamps the result to the signed byte range. The consumer takes beats through a second valid/ready handshake. A flag on the eighth beat marks the end of the group.

Top module: `requant_unit`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid` and `out_last` are 0.
- R2: `in_ready` is 0 from the cycle after a word is accepted until the cycle after the word's eighth beat is taken. It is 1 again in that following cycle.
- R3: Beat b (0..7) carries elements 8b..8b+7 of the accepted word. Element 8b+j sits in `out_data[8j+7:8j]`. Input element k sits in `in_data[32k+31:32k]`.
- R4: Each output byte is clamp(((x * scale) + r) >>> shift + zp). The terms are the signed 32-bit element x, the signed 16-bit `cfg_scale`, the 5-bit unsigned `cfg_shift` and the signed 8-bit `cfg_zero`.
- R5: With shift 0 the rounding term r is 0. With shift s > 0, r = 2^(s-1), so ties round toward positive infinity.
- R6: The clamp limits results to the range -128 to 127.
- R7: `out_last` is 1 only while beat 7 is presented.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_last` and the beat position hold.
- R9: Changes to `in_data`, `in_valid` or the configuration inputs after acceptance do not affect the beats of the accepted word.
- R10: `out_valid` rises in the cycle after acceptance with beat 0. With `out_ready` held high, the eight beats come out on eight consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_scale | input | 16 | Signed multiplier |
| cfg_shift | input | 5 | Right-shift amount, 0 to 31 |
| cfg_zero | input | 8 | Signed zero point added after the shift |
| in_valid | input | 1 | Accumulator word offered |
| in_ready | output | 1 | Unit idle and able to take a word |
| in_data | input | 2048 | 64 signed 32-bit accumulator results |
| out_valid | output | 1 | Beat presented |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 64 | Eight signed 8-bit results |
| out_last | output | 1 | Final beat of the group |

## Verification
A beat counter that skips or repeats a value shows up at once as bytes from the wrong element group. A wrong count also moves the `out_last` flag and the return of `in_ready`, and both are visible within the eight beats of the same word. Snapshot registers that are not held after acceptance show up as bytes that follow the scrambled inputs the bench drives after every handshake. Errors in rounding and clamping show up only on particular operands. For that reason directed ties, shift-0 words and overflow words are mixed with random words.

// File: rtl/requant_pkg.sv
package requant_pkg;
  localparam int ACC_W  = 32;
  localparam int SCL_W  = 16;
  localparam int SH_W   = 5;
  localparam int OUT_W  = 8;
  localparam int WIDE_W = ACC_W + SCL_W + 2;

  // Scale, round, shift, offset and clamp one accumulator value.
  function automatic logic signed [OUT_W-1:0] rq_apply(
    input logic signed [ACC_W-1:0] x,
    input logic signed [SCL_W-1:0] s,
    input logic        [SH_W-1:0]  sh,
    input logic signed [OUT_W-1:0] zp
  );
    logic signed [WIDE_W-1:0] xe, se, prod, rnd, acc;
    logic signed [WIDE_W-1:0] hi, lo;
    xe   = WIDE_W'(x);
    se   = WIDE_W'(s);
    prod = xe * se;
    if (sh == '0) rnd = '0;
    else          rnd = WIDE_W'(1) <<< (sh - SH_W'(1));
    acc  = (prod + rnd) >>> sh;
    acc  = acc + WIDE_W'(zp);
    hi   = WIDE_W'(127);
    lo   = -WIDE_W'(128);
    if (acc > hi)      return 8'sd127;
    else if (acc < lo) return -8'sd128;
    else               return acc[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/requant_seq.sv
module requant_seq #(
  parameter int BEATS  = 8,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              load,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic [BEAT_W-1:0] beat
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;
  logic              fire;

  assign in_ready  = !busy_q;
  assign load      = in_valid && !busy_q;
  assign out_valid = busy_q;
  assign out_last  = busy_q && (beat_q == LAST_BEAT);
  assign fire      = busy_q && out_ready;
  assign beat      = beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      beat_q <= '0;
    end else if (fire) begin
      if (beat_q == LAST_BEAT) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + BEAT_W'(1);
      end
    end
  end

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && beat == '0)); // R10
  AST_STALL_HOLDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(beat))); // R8
  AST_LAST_FREES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R2
  AST_BEAT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && beat == $past(beat) + BEAT_W'(1))); // R10
endmodule

// File: rtl/requant_lane.sv
module requant_lane
  import requant_pkg::*;
(
  input  logic [ACC_W-1:0] acc,
  input  logic [SCL_W-1:0] scale,
  input  logic [SH_W-1:0]  shift,
  input  logic [OUT_W-1:0] zero,
  output logic [OUT_W-1:0] q
);
  assign q = rq_apply($signed(acc), $signed(scale), shift, $signed(zero));
endmodule

// File: rtl/requant_unit.sv
module requant_unit
  import requant_pkg::*;
#(
  parameter int GROUP = 64,
  parameter int LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SCL_W-1:0]       cfg_scale,
  input  logic [SH_W-1:0]        cfg_shift,
  input  logic [OUT_W-1:0]       cfg_zero,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [GROUP*ACC_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*OUT_W-1:0] out_data,
  output logic                   out_last
);
  localparam int BEATS  = GROUP / LANES;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int IDX_W  = $clog2(GROUP);

  logic              load;
  logic [BEAT_W-1:0] beat;

  logic [ACC_W-1:0] word_q [GROUP];
  logic [SCL_W-1:0] scale_q;
  logic [SH_W-1:0]  shift_q;
  logic [OUT_W-1:0] zero_q;

  requant_seq #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .load     (load),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_last (out_last),
    .beat     (beat)
  );

  // Snapshot of word and settings taken on the accepting edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= '0;
      shift_q <= '0;
      zero_q  <= '0;
      for (int k = 0; k < GROUP; k++) word_q[k] <= '0;
    end else if (load) begin
      scale_q <= cfg_scale;
      shift_q <= cfg_shift;
      zero_q  <= cfg_zero;
      for (int k = 0; k < GROUP; k++) word_q[k] <= in_data[k*ACC_W +: ACC_W];
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IDX_W-1:0] idx;
    assign idx = IDX_W'(beat) * IDX_W'(LANES) + IDX_W'(j);
    requant_lane u_lane (
      .acc  (word_q[idx]),
      .scale(scale_q),
      .shift(shift_q),
      .zero (zero_q),
      .q    (out_data[j*OUT_W +: OUT_W])
    );
  end

  AST_STALL_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_last))); // R8
  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R7
  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
endmodule

// File: tb/tb_requant_unit.sv
module tb_requant_unit;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cfg_scale = '0;
  logic [4:0]    cfg_shift = '0;
  logic [7:0]    cfg_zero = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2047:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [63:0]   out_data;
  logic          out_last;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] wd [64];

  always #4 clk = ~clk;

  requant_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_scale(cfg_scale), .cfg_shift(cfg_shift),
    .cfg_zero(cfg_zero), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  function automatic longint model(int x, int s, int sh, int zp);
    longint v;
    v = longint'(x) * longint'(s);
    if (sh != 0) v = v + (longint'(1) << (sh - 1));
    v = v >>> sh;
    v = v + longint'(zp);
    if (v > 127)  v = 127;
    if (v < -128) v = -128;
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Offer the word in wd with given settings; then scramble inputs and collect beats.
  task automatic run_word(logic [15:0] sc, logic [4:0] sh, logic [7:0] zp, int stall_pct, string req);
    logic [63:0] held;
    for (int k = 0; k < 64; k++) in_data[k*32 +: 32] = wd[k];
    cfg_scale = sc; cfg_shift = sh; cfg_zero = zp;
    in_valid = 1'b1;
    out_ready = 1'b0;
    chk(in_ready == 1'b1, "R2", "idle in_ready", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    // R9: inputs change after acceptance
    in_valid  = ($urandom % 2) == 1;
    in_data   = {64{$urandom}};
    cfg_scale = 16'($urandom);
    cfg_shift = 5'($urandom);
    cfg_zero  = 8'($urandom);
    for (int b = 0; b < 8; b++) begin
      chk(out_valid == 1'b1, "R10", "beat valid", out_valid, 1);
      chk(in_ready == 1'b0, "R2", "busy in_ready", in_ready, 0);
      if (int'($urandom % 100) < stall_pct) begin
        out_ready = 1'b0;
        held = out_data;
        @(negedge clk);
        chk(out_valid == 1'b1 && out_data == held, "R8", "stall hold", longint'(out_data), longint'(held));
      end
      out_ready = 1'b1;
      for (int j = 0; j < 8; j++) begin
        longint e, a;
        e = model(int'($signed(wd[b*8+j])), int'($signed(sc)), int'(sh), int'($signed(zp)));
        a = longint'($signed(out_data[j*8 +: 8]));
        chk(a == e, req, $sformatf("beat %0d byte %0d (R3/R9)", b, j), a, e);
      end
      chk(out_last == (b == 7), "R7", $sformatf("last flag beat %0d", b), out_last, (b == 7));
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R2", "ready after group", in_ready, 1);
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #20;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1", "reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "idle out_valid", out_valid, 0);

    // R3: identity-like placement, element index as value
    for (int k = 0; k < 64; k++) wd[k] = 32'(k - 32);
    run_word(16'd1, 5'd0, 8'd0, 0, "R3");

    // R5: ties with shift 1 and shift 0 passthrough
    for (int k = 0; k < 64; k++) wd[k] = 32'((k % 7) - 3);
    run_word(16'd1, 5'd1, 8'd0, 0, "R5");
    run_word(16'd3, 5'd0, 8'd0, 0, "R5");
    for (int k = 0; k < 64; k++) wd[k] = 32'(k * 4 - 130);
    run_word(16'd1, 5'd3, 8'd0, 30, "R5");

    // R6: saturation both ways
    for (int k = 0; k < 64; k++) wd[k] = (k % 2) ? 32'h7FFF_FFFF : 32'h8000_0000;
    run_word(16'h7FFF, 5'd4, 8'd0, 0, "R6");
    run_word(16'h8000, 5'd31, 8'h7F, 0, "R6");
    for (int k = 0; k < 64; k++) wd[k] = 32'(k * 2);
    run_word(16'd1, 5'd0, 8'h80, 0, "R6");

    // R4: zero point and negative scale
    for (int k = 0; k < 64; k++) wd[k] = 32'($signed(32'($urandom)) >>> 20);
    run_word(16'hFFF0, 5'd9, 8'hF6, 50, "R4");

    // R4/R8/R9: random words and settings with random stalls
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < 64; k++)
        wd[k] = (t % 3 == 0) ? $urandom : 32'($signed(32'($urandom)) >>> (8 + t % 16));
      run_word(16'($urandom), 5'($urandom), 8'($urandom), 40, "R4");
    end

    // R10: back-to-back groups without stalls
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < 64; k++) wd[k] = $urandom;
      run_word(16'($urandom), 5'd20, 8'($urandom), 0, "R10");
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule